// File: doc/BRIEF.md
# MDIO Word Register Bridge

This block is a management-bus slave that opens a 32-bit, word-addressed internal register space to a host that can only issue 16-bit MDIO transfers. A 9-bit page register supplies the upper bits of the word address. The lower bits travel in the PHY address and the register number of each frame. Each 32-bit word appears as a pair of adjacent 16-bit registers: the even one carries bits 15:0 and the odd one carries bits 31:16.

The bridge oversamples the MDC and MDIO lines with the system clock and decodes clause-22 style frames. It merges each pair of half-word transfers into one atomic 32-bit access on a simple request/acknowledge register port. For a write, the host sends the high half first. The bridge parks that half internally, and the low-half write then commits the whole word in a single bus write. For a read, the host reads the low half first. That access performs the single bus read and keeps the upper half, so the high-half read that follows returns data from the same fetch.

Top module: `mdio_regbridge`

## Requirements
- R1: While reset is asserted and right after its release, `bus_req` and `mdio_oe` are low.
- R2: A write frame to PHY address 0x1F, register 0x10, loads the low 9 bits of its data into the page register. The page register supplies word-address bits 15:7 of every later bus request. A read frame to the same location returns the page value in bits 8:0, with bits 15:9 zero.
- R3: PHY addresses 0x10 to 0x17 are data windows. For a word address A, the PHY address is 0x10 | A[6:4] and the register number is {A[3:0], half}. The bus address issued is {page, PHY[2:0], register[4:1]}.
- R4: A write to an odd data register (high half) only stages its 16 bits and makes no bus access. A write to the even register then makes exactly one bus write, with data {staged high, low}.
- R5: A read of an even data register makes exactly one bus read and returns bits 15:0. A following read of the odd register returns bits 31:16 of that same fetch and makes no bus access.
- R6: Frames that target any other PHY address, or any register at PHY 0x1F other than 0x10, are ignored. They cause no bus access, no page change, and leave the line released.
- R7: In a read frame, the bridge drives 0 during the second turnaround bit, then drives 16 data bits MSB first, each changing after an MDC rising edge. It releases the line after the last data bit.
- R8: Once `bus_req` rises, it stays high with stable `bus_addr`, `bus_we` and `bus_wdata` until the cycle in which `bus_ack` is seen.
- R9: A frame is recognised only after at least PRE_LEN consecutive ones followed by the start pattern 0,1. A frame with a shorter preamble has no effect.
- R10: Frame fields are sent MSB first after the start pattern: opcode (01 = write, 10 = read), 5-bit PHY address, 5-bit register number, 2 turnaround bits (host drives 1,0 on writes), then 16 data bits. All bits are sampled on MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples MDC |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data value driven when `mdio_oe` is high |
| mdio_oe | output | 1 | Output enable for the management data line |
| bus_req | output | 1 | Internal register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Word address of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in the cycle `bus_ack` is high |
| bus_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
The checks assume that MDC is slow relative to `clk`, with each MDC phase lasting several system cycles. They also assume that `bus_ack` answers a read well within one MDC period, so the fetched low half is ready before the turnaround ends. The bench holds each MDC phase for 8 clocks and acknowledges every request 3 cycles after it rises. It raises `bus_ack` only while `bus_req` is pending, and it never releases the line during a write frame. Stimulus covers the extreme page values, all window offsets, and frames to addresses the bridge must ignore.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_BAD  = 2'b11
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e         op;
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regn;
  } mdio_hdr_t;

  localparam logic [PHY_W-1:0] PAGE_PHY   = 5'h1F;
  localparam logic [REG_W-1:0] PAGE_REG   = 5'h10;
  localparam logic [1:0]       WINDOW_TAG = 2'b10;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  input  logic              claim,
  input  logic [HALF_W-1:0] rd_half,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              hdr_valid,
  output mdio_hdr_t         hdr,
  output logic              wr_done,
  output logic [HALF_W-1:0] wr_half
);

  localparam int ONES_W = $clog2(PRE_LEN + 1);
  localparam logic [ONES_W-1:0] PRE_MAX = ONES_W'(PRE_LEN);

  typedef enum logic {ST_IDLE, ST_FRAME} fr_state_e;

  logic [2:0]        mdc_s;
  logic [1:0]        dat_s;
  logic              mdc_rise;
  logic              bit_in;

  fr_state_e         state_q, state_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [4:0]        cnt_q, cnt_d;
  logic [10:0]       hsr_q, hsr_d;
  logic [14:0]       dsr_q, dsr_d;
  logic [14:0]       tsr_q, tsr_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;
  mdio_hdr_t         hdr_q, hdr_d;
  logic              hvld_q, hvld_d;
  logic              wdone_q, wdone_d;
  logic [HALF_W-1:0] whalf_q, whalf_d;

  assign mdc_rise = mdc_s[1] & ~mdc_s[2];
  assign bit_in   = dat_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_s <= '0;
      dat_s <= '1;
    end else begin
      mdc_s <= {mdc_s[1:0], mdc};
      dat_s <= {dat_s[0], mdio_i};
    end
  end

  always_comb begin
    state_d = state_q;
    ones_d  = ones_q;
    cnt_d   = cnt_q;
    hsr_d   = hsr_q;
    dsr_d   = dsr_q;
    tsr_d   = tsr_q;
    oe_d    = oe_q;
    out_d   = out_q;
    hdr_d   = hdr_q;
    hvld_d  = 1'b0;
    wdone_d = 1'b0;
    whalf_d = whalf_q;
    if (mdc_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          if (bit_in) begin
            if (ones_q != PRE_MAX) ones_d = ones_q + 1'b1;
          end else begin
            if (ones_q == PRE_MAX) begin
              state_d = ST_FRAME;
              cnt_d   = 5'd1;
            end
            ones_d = '0;
          end
        end
        ST_FRAME: begin
          cnt_d = cnt_q + 5'd1;
          hsr_d = {hsr_q[9:0], bit_in};
          dsr_d = {dsr_q[13:0], bit_in};
          if (cnt_q == 5'd1 && !bit_in) state_d = ST_IDLE;
          if (cnt_q == 5'd13) begin
            hdr_d  = mdio_hdr_t'({hsr_q, bit_in});
            hvld_d = 1'b1;
          end
          if (cnt_q == 5'd14 && hdr_q.op == OP_RD && claim) begin
            oe_d  = 1'b1;
            out_d = 1'b0;
          end
          if (cnt_q == 5'd15 && oe_q) begin
            out_d = rd_half[HALF_W-1];
            tsr_d = rd_half[14:0];
          end
          if (cnt_q >= 5'd16 && cnt_q <= 5'd30 && oe_q) begin
            out_d = tsr_q[14];
            tsr_d = {tsr_q[13:0], 1'b0};
          end
          if (cnt_q == 5'd31) begin
            oe_d    = 1'b0;
            out_d   = 1'b0;
            state_d = ST_IDLE;
            if (hdr_q.op == OP_WR && claim) begin
              wdone_d = 1'b1;
              whalf_d = {dsr_q, bit_in};
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ones_q  <= '0;
      cnt_q   <= '0;
      hsr_q   <= '0;
      dsr_q   <= '0;
      tsr_q   <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      hdr_q   <= '0;
      hvld_q  <= 1'b0;
      wdone_q <= 1'b0;
      whalf_q <= '0;
    end else begin
      state_q <= state_d;
      ones_q  <= ones_d;
      cnt_q   <= cnt_d;
      hsr_q   <= hsr_d;
      dsr_q   <= dsr_d;
      tsr_q   <= tsr_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
      hdr_q   <= hdr_d;
      hvld_q  <= hvld_d;
      wdone_q <= wdone_d;
      whalf_q <= whalf_d;
    end
  end

  assign mdio_o    = out_q;
  assign mdio_oe   = oe_q;
  assign hdr_valid = hvld_q;
  assign hdr       = hdr_q;
  assign wr_done   = wdone_q;
  assign wr_half   = whalf_q;

endmodule

// File: rtl/mdio_addr_decode.sv
module mdio_addr_decode
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 9,
  localparam int ADDR_W = PAGE_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mdio_hdr_t         hdr,
  input  logic              wr_done,
  input  logic [PAGE_W-1:0] wr_page,
  output logic              claim,
  output logic              page_hit,
  output logic              data_hit,
  output logic              half_hi,
  output logic [ADDR_W-1:0] word_addr,
  output logic [PAGE_W-1:0] page_val
);

  logic [PAGE_W-1:0] page_q, page_d;

  assign page_hit  = (hdr.phy == PAGE_PHY) && (hdr.regn == PAGE_REG);
  assign data_hit  = (hdr.phy[4:3] == WINDOW_TAG);
  assign claim     = page_hit | data_hit;
  assign half_hi   = hdr.regn[0];
  assign word_addr = {page_q, hdr.phy[2:0], hdr.regn[4:1]};

  always_comb begin
    page_d = page_q;
    if (wr_done && page_hit && hdr.op == OP_WR) page_d = wr_page;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  assign page_val = page_q;

endmodule

// File: rtl/mdio_word_stager.sv
module mdio_word_stager
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  mdio_op_e          op,
  input  logic              data_hit,
  input  logic              half_hi,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              wr_done,
  input  logic [HALF_W-1:0] wr_half,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic [HALF_W-1:0] rd_half,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata
);

  logic [HALF_W-1:0] hold_q, hold_d;
  logic [HALF_W-1:0] lo_q, lo_d;
  logic [HALF_W-1:0] hi_q, hi_d;
  logic              req_q, req_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic              start_rd, start_wr, stage_hi;

  assign start_rd = hdr_valid && data_hit && !half_hi && op == OP_RD;
  assign start_wr = wr_done && data_hit && !half_hi;
  assign stage_hi = wr_done && data_hit && half_hi;

  always_comb begin
    hold_d  = hold_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    req_d   = req_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (req_q && bus_ack) begin
      req_d = 1'b0;
      if (!we_q) begin
        lo_d = bus_rdata[HALF_W-1:0];
        hi_d = bus_rdata[WORD_W-1:HALF_W];
      end
    end
    if (stage_hi) hold_d = wr_half;
    if (start_rd) begin
      req_d  = 1'b1;
      we_d   = 1'b0;
      addr_d = word_addr;
    end
    if (start_wr) begin
      req_d   = 1'b1;
      we_d    = 1'b1;
      addr_d  = word_addr;
      wdata_d = {hold_q, wr_half};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      hold_q  <= hold_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      req_q   <= req_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign rd_half   = half_hi ? hi_q : lo_q;
  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/mdio_regbridge.sv
module mdio_regbridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int PRE_LEN = 32,
  localparam int ADDR_W = PAGE_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              claim, page_hit, data_hit, half_hi;
  logic              hdr_valid, wr_done;
  mdio_hdr_t         hdr;
  logic [HALF_W-1:0] wr_half, rd_half, win_half;
  logic [ADDR_W-1:0] word_addr;
  logic [PAGE_W-1:0] page_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) frame_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .claim    (claim),
    .rd_half  (rd_half),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .hdr_valid(hdr_valid),
    .hdr      (hdr),
    .wr_done  (wr_done),
    .wr_half  (wr_half)
  );

  mdio_addr_decode #(.PAGE_W(PAGE_W)) decode_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hdr      (hdr),
    .wr_done  (wr_done),
    .wr_page  (wr_half[PAGE_W-1:0]),
    .claim    (claim),
    .page_hit (page_hit),
    .data_hit (data_hit),
    .half_hi  (half_hi),
    .word_addr(word_addr),
    .page_val (page_val)
  );

  mdio_word_stager #(.ADDR_W(ADDR_W)) stager_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .hdr_valid(hdr_valid),
    .op       (hdr.op),
    .data_hit (data_hit),
    .half_hi  (half_hi),
    .word_addr(word_addr),
    .wr_done  (wr_done),
    .wr_half  (wr_half),
    .bus_rdata(bus_rdata),
    .bus_ack  (bus_ack),
    .rd_half  (win_half),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
  );

  assign rd_half = page_hit ? HALF_W'(page_val) : win_half;

endmodule

// File: rtl/mdio_regbridge_chk.sv
module mdio_regbridge_chk #(
  parameter int PAGE_W = 9,
  localparam int ADDR_W = PAGE_W + 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic [PAGE_W-1:0] page_val
);

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!bus_req && !mdio_oe));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req);

  // R8
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R7
  ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R2
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (bus_addr[ADDR_W-1:7] == page_val));

endmodule

bind mdio_regbridge mdio_regbridge_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_ack  (bus_ack),
  .page_val (page_val)
);

// File: tb/mdio_regbridge_tb_top.sv
module mdio_regbridge_tb_top;

  localparam int HP = 8;
  localparam logic [1:0] WR = 2'b01;
  localparam logic [1:0] RD = 2'b10;
  localparam int NVEC = 7;
  // kind[49:48] (0 write, 1 read), word address[47:32], data[31:0]
  localparam logic [49:0] VECS [NVEC] = '{
    {2'd0, 16'h0000, 32'h1234_5678},
    {2'd0, 16'hFFFF, 32'hDEAD_BEEF},
    {2'd1, 16'h0000, 32'h0000_0000},
    {2'd1, 16'hFFFF, 32'h0000_0000},
    {2'd1, 16'h2A5B, 32'h0000_0000},
    {2'd0, 16'h8071, 32'h0F0F_A5A5},
    {2'd1, 16'h1234, 32'h0000_0000}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, mdc, m_drv, m_val;
  logic        mdio_o, mdio_oe, bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        mdio_line;

  int ntot = 0;
  int nbad = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int oe_cyc = 0;
  int dly = 0;
  logic [15:0] last_addr = '0;
  logic [31:0] last_data = '0;
  logic finished = 1'b0;

  function automatic logic [31:0] model(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  assign mdio_line = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);
  assign bus_rdata = model(bus_addr);

  mdio_regbridge dut_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      dly <= 0;
    end else if (bus_req && !bus_ack) begin
      if (dly == 2) begin
        bus_ack <= 1'b1;
        dly <= 0;
        last_addr <= bus_addr;
        if (bus_we) begin
          wr_cnt <= wr_cnt + 1;
          last_data <= bus_wdata;
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        dly <= dly + 1;
      end
    end else begin
      bus_ack <= 1'b0;
    end
    if (mdio_oe) oe_cyc <= oe_cyc + 1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic drv, input logic val, output logic smp);
    @(negedge clk);
    m_drv = drv;
    m_val = val;
    mdc = 1'b0;
    repeat (HP - 1) @(negedge clk);
    smp = mdio_line;
    mdc = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd,
                       output logic [15:0] rd, output logic ta);
    logic s;
    rd = '0;
    ta = 1'b1;
    for (int k = 0; k < pre; k++) mbit(1'b1, 1'b1, s);
    mbit(1'b1, 1'b0, s);
    mbit(1'b1, 1'b1, s);
    for (int k = 1; k >= 0; k--) mbit(1'b1, op[k], s);
    for (int k = 4; k >= 0; k--) mbit(1'b1, phy[k], s);
    for (int k = 4; k >= 0; k--) mbit(1'b1, rg[k], s);
    if (op == WR) begin
      mbit(1'b1, 1'b1, s);
      mbit(1'b1, 1'b0, s);
      for (int k = 15; k >= 0; k--) mbit(1'b1, wd[k], s);
    end else begin
      mbit(1'b0, 1'b0, s);
      mbit(1'b0, 1'b0, ta);
      for (int k = 15; k >= 0; k--) begin
        mbit(1'b0, 1'b0, s);
        rd[k] = s;
      end
    end
    @(negedge clk);
    m_drv = 1'b0;
    mdc = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic set_page(input logic [8:0] pg);
    logic [15:0] r;
    logic t;
    frame(32, WR, 5'h1F, 5'h10, {7'b0, pg}, r, t);
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] d);
    logic [15:0] r;
    logic t;
    int w0;
    set_page(a[15:7]);
    w0 = wr_cnt;
    frame(32, WR, {2'b10, a[6:4]}, {a[3:0], 1'b1}, d[31:16], r, t);
    chk(wr_cnt == w0, "R4 high half only staged", wr_cnt, w0);
    frame(32, WR, {2'b10, a[6:4]}, {a[3:0], 1'b0}, d[15:0], r, t);
    chk(wr_cnt == w0 + 1, "R4 low half commits one write", wr_cnt, w0 + 1);
    chk(last_addr == a, "R3 write word address", {16'b0, last_addr}, {16'b0, a});
    chk(last_data == d, "R4 written word", last_data, d);
  endtask

  task automatic rd32(input logic [15:0] a);
    logic [15:0] r;
    logic t;
    int r0;
    logic [31:0] e;
    e = model(a);
    set_page(a[15:7]);
    r0 = rd_cnt;
    frame(32, RD, {2'b10, a[6:4]}, {a[3:0], 1'b0}, 16'h0, r, t);
    chk(rd_cnt == r0 + 1, "R5 low read fetches once", rd_cnt, r0 + 1);
    chk(last_addr == a, "R3 read word address", {16'b0, last_addr}, {16'b0, a});
    chk(r == e[15:0], "R5 low half data", {16'b0, r}, {16'b0, e[15:0]});
    chk(t == 1'b0, "R7 turnaround driven low", {31'b0, t}, 32'h0);
    frame(32, RD, {2'b10, a[6:4]}, {a[3:0], 1'b1}, 16'h0, r, t);
    chk(rd_cnt == r0 + 1, "R5 high read no bus access", rd_cnt, r0 + 1);
    chk(r == e[31:16], "R5 high half data", {16'b0, r}, {16'b0, e[31:16]});
    chk(mdio_oe == 1'b0, "R7 line released after read", {31'b0, mdio_oe}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      ntot++;
      $display("FAIL watchdog expired act=%0d exp=0", 1);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic t;
    int w0, r0, o0;
    rst_n = 1'b1;
    mdc = 1'b0;
    m_drv = 1'b0;
    m_val = 1'b1;
    #2 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(bus_req == 1'b0, "R1 bus_req low in reset", {31'b0, bus_req}, 32'h0);
    chk(mdio_oe == 1'b0, "R1 mdio_oe low in reset", {31'b0, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0 && mdio_oe == 1'b0, "R1 idle after reset",
        {30'b0, bus_req, mdio_oe}, 32'h0);

    // R10 R3 R4 R5: vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][49:48] == 2'd0) wr32(VECS[i][47:32], VECS[i][31:0]);
      else                        rd32(VECS[i][47:32]);
    end

    // R2 page readback
    set_page(9'h0C3);
    frame(32, RD, 5'h1F, 5'h10, 16'h0, r, t);
    chk(r == 16'h00C3, "R2 page readback", {16'b0, r}, 32'h00C3);
    set_page(9'h1FF);
    frame(32, RD, 5'h1F, 5'h10, 16'h0, r, t);
    chk(r == 16'h01FF, "R2 page readback upper bits zero", {16'b0, r}, 32'h01FF);

    // R6 foreign PHY and other register at page PHY
    set_page(9'h0C3);
    frame(32, WR, 5'h05, 5'h10, 16'h0055, r, t);
    frame(32, WR, 5'h1F, 5'h11, 16'h0066, r, t);
    frame(32, RD, 5'h1F, 5'h10, 16'h0, r, t);
    chk(r == 16'h00C3, "R6 page unchanged by ignored frames", {16'b0, r}, 32'h00C3);
    w0 = wr_cnt;
    frame(32, WR, 5'h18, 5'h03, 16'hAAAA, r, t);
    frame(32, WR, 5'h0F, 5'h02, 16'h5555, r, t);
    chk(wr_cnt == w0, "R6 no bus write for foreign PHY", wr_cnt, w0);
    r0 = rd_cnt;
    o0 = oe_cyc;
    frame(32, RD, 5'h0F, 5'h00, 16'h0, r, t);
    chk(r == 16'hFFFF, "R6 line released on foreign read", {16'b0, r}, 32'hFFFF);
    chk(oe_cyc == o0, "R6 no drive on foreign read", oe_cyc, o0);
    chk(rd_cnt == r0, "R6 no bus read for foreign PHY", rd_cnt, r0);

    // R9 short preamble ignored
    frame(16, WR, 5'h1F, 5'h10, 16'h0055, r, t);
    frame(32, RD, 5'h1F, 5'h10, 16'h0, r, t);
    chk(r == 16'h00C3, "R9 short preamble ignored", {16'b0, r}, 32'h00C3);

    // R4 staged high half survives a page change before the low write
    set_page(9'h002);
    frame(32, WR, 5'h13, 5'h07, 16'hCAFE, r, t);
    set_page(9'h005);
    w0 = wr_cnt;
    frame(32, WR, 5'h13, 5'h06, 16'hF00D, r, t);
    chk(wr_cnt == w0 + 1, "R4 single commit", wr_cnt, w0 + 1);
    chk(last_data == 32'hCAFE_F00D, "R4 staged half merged", last_data, 32'hCAFE_F00D);
    chk(last_addr == 16'h02B3, "R3 address uses current page", {16'b0, last_addr}, 32'h02B3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

endmodule